// File: doc/BRIEF.md
# Presettable Cascadable Down Counter Stage

This block is one digit of a programmable frequency divider. It holds a binary count that is loaded from a parallel preset value and then stepped down by one on each counting event. It reports a zero flag when the count reaches zero. A counting event is a rising edge on the count clock input. A falling edge on the inhibit input also counts, provided the count clock is held high at that moment. A high level on inhibit blocks counting from rising edges.

All logic runs on a fast system clock. The count clock, inhibit, clear and load-enable inputs pass through a two-flop synchronizer first. Each counting event then produces exactly one single-cycle decrement. Clear wins over load, and load wins over decrement.

The zero flag can only be high when the cascade input is high. It is also suppressed while a load is in progress. For single-stage divide-by-N use, the zero flag is wired back to load enable, so reaching zero reloads N. For wider dividers, several stages are chained. The most significant stage has its cascade input tied high, and each stage's zero flag drives the cascade input of the next lower stage. The last zero flag then rises only when every digit is zero. That flag is fed back to the load enable of all stages.

Top module: `dnc_stage`

## Requirements
- R1: While the synchronized clear input is high, the count is forced to zero. This overrides load enable and counting events. With the cascade input high, zero_o is high throughout the clear, even if load enable is also high.
- R2: With clear low and load enable high, the count takes the value of load_val_i (bit 0 is the LSB). While load enable stays high, counting events have no effect.
- R3: With clear, load enable and inhibit low, each rising edge of cnt_clk_i decrements the count by exactly one.
- R4: While inhibit is high, rising edges of cnt_clk_i leave the count unchanged.
- R5: With cnt_clk_i held high, a falling edge of hold_i decrements the count by one. A falling edge of cnt_clk_i never changes the count.
- R6: Decrementing from zero gives the all-ones value (15 for the default 4-bit width).
- R7: zero_o is high when the cascade input is high, the count is zero and no load is in progress. zero_o is low whenever the count is nonzero.
- R8: zero_o is low whenever casc_i is low, whatever the count.
- R9: A change on cnt_clk_i, hold_i, clear_i or load_en_i shows on count_o after the third rising edge of clk following the change, and not after the second.
- R10: With zero_o fed back to load_en_i, a single stage emits one zero pulse per N counting events. Three chained stages give the same for a 12-bit N, including N = 1. In the chain, each upper stage is inhibited while any lower stage is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| cnt_clk_i | input | 1 | Count clock; rising edge decrements |
| hold_i | input | 1 | Inhibit; high blocks counting, falling edge counts while cnt_clk_i is high |
| clear_i | input | 1 | Forces the count to zero |
| load_en_i | input | 1 | Loads load_val_i into the count |
| load_val_i | input | CNT_W | Preset value, bit 0 is the LSB |
| casc_i | input | 1 | Cascade input that gates the zero flag |
| count_o | output | CNT_W | Current count |
| zero_o | output | 1 | Zero flag |

## Verification
The bench aims at the edges where a counter most easily goes wrong. It checks the wrap from zero to all ones; a design that saturates would stick at zero. It checks a falling inhibit edge while the clock is high; a design that ignores it would lose a count, and one that counts a falling clock edge would gain one. It checks clear and load asserted together, which catches a swapped priority, and counting while load is held, which catches a load that fails to block decrements. A three-stage chain with reload from the zero flag is run for N = 1, 5 and 300. A wrong cascade gate or a reload race would show up there as a wrong pulse count or a wrong combined value.

// File: rtl/dnc_pkg.sv
package dnc_pkg;

    typedef enum logic [1:0] {
        ACT_IDLE,
        ACT_DEC,
        ACT_LOAD,
        ACT_CLEAR
    } dnc_act_e;

    typedef struct packed {
        logic cnt_clk;
        logic hold;
    } dnc_edge_t;

endpackage

// File: rtl/dnc_sync.sv
module dnc_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/dnc_edge.sv
module dnc_edge
    import dnc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cnt_clk_s,
    input  logic hold_s,
    output logic dec_o
);
    dnc_edge_t prev_d, prev_q;
    logic      clk_rise, hold_fall;

    always_comb begin
        prev_d.cnt_clk = cnt_clk_s;
        prev_d.hold    = hold_s;
        clk_rise  = cnt_clk_s & ~prev_q.cnt_clk & ~hold_s;
        hold_fall = prev_q.hold & ~hold_s & cnt_clk_s;
        dec_o     = clk_rise | hold_fall;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    // R4: no counting event while inhibit is held high
    a_r4_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_s && prev_q.hold) |-> !dec_o);
    // R5: a falling count clock never produces an event
    a_r5_no_fall_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_clk_s) |-> !dec_o);
endmodule

// File: rtl/dnc_zero.sv
module dnc_zero #(
    parameter int CNT_W = 4
) (
    input  logic [CNT_W-1:0] count,
    input  logic             casc,
    input  logic             load_s,
    input  logic             clear_s,
    output logic             zero
);
    always_comb begin
        zero = casc & (count == '0) & (clear_s | ~load_s);
    end
endmodule

// File: rtl/dnc_stage.sv
module dnc_stage
    import dnc_pkg::*;
#(
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_clk_i,
    input  logic             hold_i,
    input  logic             clear_i,
    input  logic             load_en_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             casc_i,
    output logic [CNT_W-1:0] count_o,
    output logic             zero_o
);
    localparam int NCTRL = 4;

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } stage_t;

    logic [NCTRL-1:0] ctrl_raw, ctrl_s;
    logic             clk_s, hold_s, clear_s, load_s, dec;
    dnc_act_e         act;
    stage_t           st_d, st_q;

    assign ctrl_raw = {clear_i, load_en_i, hold_i, cnt_clk_i};
    assign clk_s    = ctrl_s[0];
    assign hold_s   = ctrl_s[1];
    assign load_s   = ctrl_s[2];
    assign clear_s  = ctrl_s[3];

    dnc_sync #(.W(NCTRL), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ctrl_raw),
        .q     (ctrl_s)
    );

    dnc_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_clk_s (clk_s),
        .hold_s    (hold_s),
        .dec_o     (dec)
    );

    always_comb begin
        st_d = st_q;
        if (clear_s)     act = ACT_CLEAR;
        else if (load_s) act = ACT_LOAD;
        else if (dec)    act = ACT_DEC;
        else             act = ACT_IDLE;
        case (act)
            ACT_CLEAR: st_d.count = '0;
            ACT_LOAD:  st_d.count = load_val_i;
            ACT_DEC:   st_d.count = st_q.count - 1'b1;
            default:   st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.count;

    dnc_zero #(.CNT_W(CNT_W)) u_zero (
        .count   (st_q.count),
        .casc    (casc_i),
        .load_s  (load_s),
        .clear_s (clear_s),
        .zero    (zero_o)
    );

    // R1: clear forces zero on the next edge
    a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear_s |=> (count_o == '0));
    // R2: load takes the preset value
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_s && load_s) |=> (count_o == $past(load_val_i)));
    // R3 and R6: one event lowers the count by exactly one, modulo 2^CNT_W
    a_r3_dec_one: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_s && !load_s && dec) |=> (count_o == CNT_W'($past(count_o) - 1'b1)));
    // R4: without event, load or clear the count holds
    a_r4_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_s && !load_s && !dec) |=> $stable(count_o));
    // R7: the zero flag implies a zero count
    a_r7_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        zero_o |-> (count_o == '0));
    // R8: cascade low keeps the zero flag low
    a_r8_casc_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !casc_i |-> !zero_o);
endmodule

// File: tb/dnc_stage_tb_top.sv
`timescale 1ns/1ps
module dnc_stage_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // standalone stage
    logic       s_clk = 0, s_hold = 0, s_clear = 0, s_load = 0, s_casc = 1, tie_mode = 0;
    logic [3:0] s_val = 0;
    logic [3:0] s_cnt;
    logic       s_zero, s_load_in;
    assign s_load_in = tie_mode ? s_zero : s_load;

    dnc_stage dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_clk_i(s_clk), .hold_i(s_hold),
        .clear_i(s_clear), .load_en_i(s_load_in), .load_val_i(s_val),
        .casc_i(s_casc), .count_o(s_cnt), .zero_o(s_zero)
    );

    // three-stage chain
    logic        k_clk = 0, k_clear = 0;
    logic [11:0] k_n = 12'd1;
    logic [3:0]  k_c0, k_c1, k_c2;
    logic        k_z0, k_z1, k_z2, k_h1, k_h2;
    assign k_h1 = (k_c0 != 4'd0);
    assign k_h2 = (k_c0 != 4'd0) || (k_c1 != 4'd0);

    dnc_stage u_c2 (.clk(clk), .rst_n(rst_n), .cnt_clk_i(k_clk), .hold_i(k_h2),
        .clear_i(k_clear), .load_en_i(k_z0), .load_val_i(k_n[11:8]),
        .casc_i(1'b1), .count_o(k_c2), .zero_o(k_z2));
    dnc_stage u_c1 (.clk(clk), .rst_n(rst_n), .cnt_clk_i(k_clk), .hold_i(k_h1),
        .clear_i(k_clear), .load_en_i(k_z0), .load_val_i(k_n[7:4]),
        .casc_i(k_z2), .count_o(k_c1), .zero_o(k_z1));
    dnc_stage u_c0 (.clk(clk), .rst_n(rst_n), .cnt_clk_i(k_clk), .hold_i(1'b0),
        .clear_i(k_clear), .load_en_i(k_z0), .load_val_i(k_n[3:0]),
        .casc_i(k_z1), .count_o(k_c0), .zero_o(k_z0));

    // zero pulse monitors
    int  k_pulses = 0, s_pulses = 0;
    logic k_zp = 0, s_zp = 0;
    always @(posedge clk) begin
        k_zp <= k_z0;
        s_zp <= s_zero;
        if (k_z0 && !k_zp) k_pulses <= k_pulses + 1;
        if (s_zero && !s_zp) s_pulses <= s_pulses + 1;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    function automatic logic [3:0] dec4(input logic [3:0] v);
        return v - 4'd1;
    endfunction

    function automatic logic [11:0] div_next(input logic [11:0] v, input logic [11:0] n);
        return (v == 12'd1) ? n : v - 12'd1;
    endfunction

    logic [3:0] exp_cnt = 0;

    task automatic s_pulse();
        s_clk = 1; tick(4); s_clk = 0; tick(4);
    endtask

    task automatic s_hold_fall();
        s_hold = 1; tick(4); s_clk = 1; tick(4); s_hold = 0; tick(4); s_clk = 0; tick(4);
    endtask

    task automatic s_do_load(input logic [3:0] v);
        s_val = v; s_load = 1; tick(4); s_load = 0; tick(4);
    endtask

    task automatic k_event();
        k_clk = 1; tick(1); k_clk = 0; tick(8);
    endtask

    task automatic run_chain(input logic [11:0] n, input int events);
        logic [11:0] v;
        int base;
        k_n = n;
        k_clear = 1; tick(6); k_clear = 0; tick(10);
        v = n;
        check("R10 chain load", int'({k_c2, k_c1, k_c0}), int'(n));
        base = k_pulses;
        for (int e = 0; e < events; e++) begin
            k_event();
            v = div_next(v, n);
            check("R10 chain count", int'({k_c2, k_c1, k_c0}), int'(v));
        end
        check("R10 chain pulses", k_pulses - base, events / int'(n));
    endtask

    initial begin
        logic [1:0] op;
        logic [3:0] rv;
        tick(3);
        rst_n = 1;
        tick(2);
        check("R1 reset count", s_cnt, 0);
        check("R7 zero at reset", s_zero, 1);

        // R9 latency and R2 load
        s_val = 4'd9; s_load = 1;
        tick(2);
        check("R9 not after two edges", s_cnt, 0);
        tick(1);
        check("R9 after three edges R2 load", s_cnt, 9);
        check("R7 zero low on nonzero", s_zero, 0);
        s_pulse();
        check("R2 counting blocked during load", s_cnt, 9);
        s_load = 0; tick(4);

        s_clk = 1; tick(4);
        check("R3 rising edge decrements", s_cnt, 8);
        s_clk = 0; tick(4);
        check("R5 falling clock ignored", s_cnt, 8);

        s_hold = 1; tick(4); s_pulse();
        check("R4 inhibit blocks", s_cnt, 8);
        s_hold = 0; tick(4);

        s_hold_fall();
        check("R5 inhibit falling edge counts", s_cnt, 7);

        s_do_load(4'd0);
        check("R7 zero flag at zero", s_zero, 1);
        s_casc = 0; tick(1);
        check("R8 cascade low gates zero", s_zero, 0);
        s_casc = 1; tick(1);

        s_pulse();
        check("R6 wrap to all ones", s_cnt, 15);
        check("R7 zero low after wrap", s_zero, 0);

        s_val = 4'd5; s_load = 1; s_clear = 1; tick(5);
        check("R1 clear beats load", s_cnt, 0);
        check("R1 zero high during clear", s_zero, 1);
        s_clear = 0; tick(4);
        check("R2 load after clear release", s_cnt, 5);
        s_load = 0; tick(4);

        // R10 single-stage divide-by-3
        s_val = 4'd3; tie_mode = 1;
        s_clear = 1; tick(5); s_clear = 0; tick(8);
        begin
            int b;
            b = s_pulses;
            for (int i = 0; i < 9; i++) s_pulse();
            check("R10 single stage pulses", s_pulses - b, 3);
        end
        tie_mode = 0; tick(4);

        // constrained random mix against the model
        s_do_load(4'd2);
        exp_cnt = 4'd2;
        void'($urandom(32'd1234));
        for (int i = 0; i < 60; i++) begin
            op = 2'($urandom_range(0, 2));
            case (op)
                2'd0: begin
                    s_hold = 1'($urandom_range(0, 1)); tick(4);
                    s_pulse();
                    if (!s_hold) exp_cnt = dec4(exp_cnt);
                    check("R3 R4 random pulse", s_cnt, exp_cnt);
                    s_hold = 0; tick(4);
                end
                2'd1: begin
                    s_hold_fall();
                    exp_cnt = dec4(exp_cnt);
                    check("R5 random inhibit edge", s_cnt, exp_cnt);
                end
                default: begin
                    rv = 4'($urandom_range(0, 15));
                    s_do_load(rv);
                    exp_cnt = rv;
                    check("R2 random load", s_cnt, exp_cnt);
                end
            endcase
            check("R7 random zero flag", s_zero, (exp_cnt == 4'd0) ? 1 : 0);
        end

        // R10 three-stage chain
        run_chain(12'd1, 20);
        run_chain(12'd5, 20);
        run_chain(12'd300, 600);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog expired actual=1 expected=0");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule